// File: doc/BRIEF.md
# Isolated Output Power Sequencing Controller

This block decides what the open-drain output pin of a two-domain isolated comparator shows while its two supplies come and go. It watches a supply-good flag from the low-voltage side, which carries the output pin, and one from the high-voltage side, which carries the comparator. It then selects one of three output conditions: released (Hi-Z), held low to signal that the high side has no power, or following the live comparator result.

All timing windows are counted in clock cycles and set by parameters. These windows are the low-side start-up time, the combined high-side start-up and blanking time, and the fault-detection time. The fault-detection time must be shorter than the high-side window. Both supply flags arrive asynchronously and pass through two-flop synchronizers. The pin itself is modelled as a pull-down enable, and a two-bit code reports which condition is active.

Top module: `iso_out_seq`

## Requirements
- R1: After reset, and whenever the low-side flag first becomes good, the output is released: status code 2'b00 and pull-down enable 0.
- R2: If the high side is not ready once the low-side start-up window (LS_START_CYC) has elapsed, and stays not ready for a further FAULT_CYC cycles, the block enters the fault state: status 2'b01, pull-down enable 1. The fault state is not entered earlier than LS_START_CYC + FAULT_CYC cycles after the low-side flag rises.
- R3: In normal operation, a loss of the high-side flag that lasts longer than FAULT_CYC cycles moves the block to the fault state. A loss shorter than FAULT_CYC cycles leaves status 2'b10 unchanged.
- R4: Normal operation (status 2'b10) is entered only after the high-side flag has been continuously good for HS_START_CYC + HS_BLANK_CYC cycles.
- R5: When the high side comes up shortly after the low side, the sequence is released, then fault, then normal.
- R6: Loss of the low-side flag forces the released state within three clock cycles, from any state, overriding every timer.
- R7: If the high side is already fully ready when the low-side flag rises, the output goes from released directly to normal after the low-side start-up window, with no cycle of pull-down.
- R8: If the high side fails and the low side fails later, the output is first held low and is then released once the low-side loss is seen.
- R9: In normal operation the pull-down enable is 1 when the comparator result is 0, and 0 when it is 1.
- R10: A loss of the high-side flag before its start-up plus blanking window completes restarts that window from zero when the flag returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lo_good_a | input | 1 | Low-side supply-good flag, asynchronous |
| hi_good_a | input | 1 | High-side supply-good flag, asynchronous |
| cmp_in | input | 1 | Comparator result (1 = output high) |
| pd_en | output | 1 | Open-drain pull-down enable |
| status | output | 2 | 00 released, 01 fault low, 10 normal |

## Verification
The supplies are sequenced in several orders: low side alone, high side arriving long after, high side arriving shortly after, high side already up before the low side, and each side failing first. These orders separate the three output conditions and the paths between them. For every delay, one sample is taken just before the earliest legal transition and one shortly after it, so a window that is too short or too long is caught. High-side glitches just shorter than the fault window, and glitches inside the start-up window, tell apart a filter that tolerates short loss from a timer that restarts.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;
  typedef enum logic [1:0] {
    ST_HIZ = 2'b00,
    ST_FLT = 2'b01,
    ST_RUN = 2'b10
  } out_state_e;
endpackage

// File: rtl/iso_flag_sync.sv
module iso_flag_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)             cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIM);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done) |=> done); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/iso_out_seq.sv
module iso_out_seq
  import iso_seq_pkg::*;
#(
  parameter int unsigned LS_START_CYC = 16,
  parameter int unsigned HS_START_CYC = 8,
  parameter int unsigned HS_BLANK_CYC = 32,
  parameter int unsigned FAULT_CYC    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_good_a,
  input  logic       hi_good_a,
  input  logic       cmp_in,
  output logic       pd_en,
  output logic [1:0] status
);
  localparam int unsigned HS_WIN_CYC = HS_START_CYC + HS_BLANK_CYC;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // supply flags into the clock domain
  logic [1:0] flags_s;
  logic       lo_s;
  logic       hi_s;

  iso_flag_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({hi_good_a, lo_good_a}),
    .q     (flags_s)
  );
  assign lo_s = flags_s[0];
  assign hi_s = flags_s[1];

  out_state_e state_q;
  out_state_e state_d;

  // timers
  logic ls_done;
  logic hs_done;
  logic flt_done;
  logic hs_run;
  logic hs_ok;
  logic flt_run;

  iso_cycle_timer #(.LIMIT(LS_START_CYC)) u_ls_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (lo_s),
    .done  (ls_done)
  );

  // in normal operation a short high-side loss keeps the window complete;
  // elsewhere a loss restarts it
  assign hs_run = hi_s || (state_q == ST_RUN);

  iso_cycle_timer #(.LIMIT(HS_WIN_CYC)) u_hs_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (hs_run),
    .done  (hs_done)
  );

  assign hs_ok   = hi_s && hs_done;
  assign flt_run = lo_s && ls_done && !hs_ok;

  iso_cycle_timer #(.LIMIT(FAULT_CYC)) u_flt_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (flt_run),
    .done  (flt_done)
  );

  // next state
  always_comb begin
    state_d = state_q;
    if (!lo_s) begin
      state_d = ST_HIZ;
    end else begin
      unique case (state_q)
        ST_HIZ: begin
          if (ls_done && hs_ok) state_d = ST_RUN;
          else if (flt_done)    state_d = ST_FLT;
        end
        ST_FLT: if (hs_ok)    state_d = ST_RUN;
        ST_RUN: if (flt_done) state_d = ST_FLT;
        default:              state_d = ST_HIZ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_HIZ;
    else             state_q <= state_d;
  end

  assign pd_en  = (state_q == ST_FLT) || ((state_q == ST_RUN) && !cmp_in);
  assign status = state_q;

  AST_HIZ_ON_LS_LOSS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lo_s |=> (state_q == ST_HIZ)); // R6
  AST_HIZ_RELEASED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_HIZ) |-> !pd_en); // R1
  AST_RUN_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(state_q == ST_RUN) |-> $past(hs_done)); // R4
  AST_FLT_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(state_q == ST_FLT) |-> $past(flt_done)); // R2
  AST_NO_LOW_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_HIZ && lo_s && ls_done && hs_ok) |=> (state_q != ST_FLT)); // R7
endmodule

// File: tb/sim_iso_out_seq.sv
module sim_iso_out_seq;
  localparam int LS  = 6;
  localparam int HSS = 4;
  localparam int BLK = 12;
  localparam int FLT = 5;

  logic       clk;
  logic       rst_n;
  logic       lo_good_a;
  logic       hi_good_a;
  logic       cmp_in;
  logic       pd_en;
  logic [1:0] status;

  int checks;
  int errors;
  bit finished;

  iso_out_seq #(
    .LS_START_CYC (LS),
    .HS_START_CYC (HSS),
    .HS_BLANK_CYC (BLK),
    .FAULT_CYC    (FLT)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_good_a (lo_good_a),
    .hi_good_a (hi_good_a),
    .cmp_in    (cmp_in),
    .pd_en     (pd_en),
    .status    (status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_code(input logic [1:0] exp, input string req);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: status actual %b expected %b at %0t", req, status, exp, $time);
    end
  endtask

  task automatic chk_pd(input logic exp, input string req);
    checks++;
    if (pd_en !== exp) begin
      errors++;
      $display("FAIL %s: pd_en actual %b expected %b at %0t", req, pd_en, exp, $time);
    end
  endtask

  task automatic t_reset;
    chk_code(2'b00, "R1");
    chk_pd(1'b0, "R1");
  endtask

  task automatic t_hs_missing;
    lo_good_a = 1'b1;
    tick(2);
    chk_code(2'b00, "R1");
    tick(LS + FLT - 2);
    chk_code(2'b00, "R2");
    tick(5);
    chk_code(2'b01, "R2");
    chk_pd(1'b1, "R2");
  endtask

  task automatic t_hs_late;
    hi_good_a = 1'b1;
    tick(HSS + BLK);
    chk_code(2'b01, "R4");
    tick(5);
    chk_code(2'b10, "R4");
    chk_pd(1'b0, "R9");
  endtask

  task automatic t_follow;
    cmp_in = 1'b0;
    tick(1);
    chk_pd(1'b1, "R9");
    cmp_in = 1'b1;
    tick(1);
    chk_pd(1'b0, "R9");
  endtask

  task automatic t_short_loss;
    bit bad;
    bad = 1'b0;
    hi_good_a = 1'b0;
    tick(FLT - 2);
    hi_good_a = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      if (status !== 2'b10) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R3: short loss left normal, actual %b expected 10", status);
    end
  endtask

  task automatic t_long_loss;
    hi_good_a = 1'b0;
    tick(FLT);
    chk_code(2'b10, "R3");
    tick(5);
    chk_code(2'b01, "R3");
    chk_pd(1'b1, "R3");
  endtask

  task automatic t_ls_off_after_fault;
    lo_good_a = 1'b0;
    tick(1);
    chk_code(2'b01, "R8");
    tick(2);
    chk_code(2'b00, "R8");
    chk_pd(1'b0, "R6");
  endtask

  task automatic t_hs_first;
    bit bad;
    bad = 1'b0;
    hi_good_a = 1'b1;
    tick(HSS + BLK + 8);
    lo_good_a = 1'b1;
    for (int i = 1; i <= LS + 6; i++) begin
      tick(1);
      if (pd_en !== 1'b0 || status === 2'b01) bad = 1'b1;
      if (i == LS) chk_code(2'b00, "R7");
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R7: low pulse seen, actual pd_en %b expected 0", pd_en);
    end
    chk_code(2'b10, "R7");
  endtask

  task automatic t_ls_off_in_run;
    cmp_in = 1'b0;
    tick(1);
    chk_pd(1'b1, "R9");
    lo_good_a = 1'b0;
    tick(3);
    chk_code(2'b00, "R6");
    chk_pd(1'b0, "R6");
    cmp_in = 1'b1;
  endtask

  task automatic t_window_restart;
    hi_good_a = 1'b0;
    tick(4);
    lo_good_a = 1'b1;
    tick(LS + FLT + 5);
    chk_code(2'b01, "R10");
    hi_good_a = 1'b1;
    tick(HSS + BLK - 4);
    hi_good_a = 1'b0;
    tick(3);
    hi_good_a = 1'b1;
    tick(HSS + BLK - 2);
    chk_code(2'b01, "R10");
    tick(7);
    chk_code(2'b10, "R10");
  endtask

  task automatic t_close_start;
    lo_good_a = 1'b0;
    hi_good_a = 1'b0;
    tick(5);
    lo_good_a = 1'b1;
    tick(LS);
    chk_code(2'b00, "R5");
    tick(2);
    hi_good_a = 1'b1;
    tick(10);
    chk_code(2'b01, "R5");
    tick(12);
    chk_code(2'b10, "R5");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    lo_good_a = 1'b0;
    hi_good_a = 1'b0;
    cmp_in = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_hs_missing();
    t_hs_late();
    t_follow();
    t_short_loss();
    t_long_loss();
    t_ls_off_after_fault();
    t_hs_first();
    t_ls_off_in_run();
    t_window_restart();
    t_close_start();
    finish_run();
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish_run();
  end
endmodule